// File: doc/BRIEF.md
# Serial RTC Access Sequencer

This block is a hardware master that performs one register read or one register write on an always-on real-time-clock target. The target sits behind a four-wire bit-serial link: an enable, a serial clock, data towards the target and data back from it. A separate ready flag shows that the target can accept a frame. A host raises a one-cycle request with a direction flag, a 3-bit register address and, for writes, a 32-bit word. The sequencer then brings the link up, shifts the frame out bit by bit, and, on a read, clocks 32 bits back in. It finishes with a one-cycle completion pulse.

Bringing the link up can fail. The sequencer polls the ready flag in bounded windows and kicks the flag after each empty window. A bring-up attempt that stays unsuccessful is retried after a pause. Every fourth failed attempt makes the sequencer ask for a static-register reset of the target. If the target still does not answer after three such resets, the transaction ends with an error. Every delay is a count of system clock cycles set by a parameter, so the link timing follows the clock frequency.

Top module: `rtc_serial_seq`

## Requirements
- R1: After reset, link_sen, link_sclk, link_sdi, done, err, busy_rej, rdy_kick and srst_req are 0 and rd_data is 0.
- R2: A write (req_wr=1) sends, with link_sen high, the 32 data bits most significant first and then the 3 address bits most significant first. It then sends one mode pulse with link_sen low and link_sdi=1.
- R3: A read (req_wr=0) sends the 3 address bits with link_sen high and then a mode pulse with link_sen low and link_sdi=0. It then gives 32 further clock pulses and samples link_sdo once per pulse. The first sampled bit becomes rd_data[31].
- R4: Each clock pulse stays low for LINK_DLY cycles with link_sdi already valid, then high for LINK_DLY cycles. link_sdi does not change while link_sclk is high.
- R5: During bring-up link_sen, link_sclk and link_sdi are low. link_sen rises only after tgt_ready has been seen high, and it rises before the first bit is clocked.
- R6: A polling window of POLL_LIMIT cycles that does not see tgt_ready ends in a one-cycle rdy_kick pulse and a PAUSE_DLY pause. The exception is every (RETRY+1)-th window of an attempt, which ends the attempt as failed and gives no kick. If ready first appears after k kicks, exactly k kicks occur.
- R7: Every (RETRY+1)-th consecutive failed attempt gives a one-cycle srst_req with srst_val = 0x180A, unless RETRY such resets have already been issued. In that case done and err pulse together, no bit is clocked, and rdy_kick has pulsed RETRY*(RETRY+1)^2 times.
- R8: done pulses for exactly one cycle per accepted transaction. err is high only together with done.
- R9: A request while a transaction is in progress gives busy_rej high in the next cycle and leaves the running frame unchanged.
- R10: rd_data changes only when a read completes successfully. Writes and failed transactions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle transaction request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Target register address |
| req_wdata | input | 32 | Write word |
| rd_data | output | 32 | Last word read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Bring-up gave up (with done) |
| busy_rej | output | 1 | Request refused because busy |
| link_sen | output | 1 | Link enable |
| link_sclk | output | 1 | Link serial clock |
| link_sdi | output | 1 | Data towards the target |
| link_sdo | input | 1 | Data from the target |
| tgt_ready | input | 1 | Target ready flag |
| rdy_kick | output | 1 | One-cycle kick of the ready flag |
| srst_req | output | 1 | One-cycle static-register reset request |
| srst_val | output | 16 | Value for the static-register reset |

## Verification
Two events can land in the same cycle: a host request arriving and the sequencer's own progress, which may be a bring-up kick or a bit on the wire. The bench provokes this by raising a second request, with inverted direction, address and data, a few cycles into a transaction while bring-up is still polling. It then checks that busy_rej rises one cycle later and that the frame it decodes from the link still carries the first request's fields. The same bench-side link decoder judges the frame order, the mode bit, the bit timing, and the counts of kicks and resets against values computed from the ready delay it chose.

// File: rtl/rtc_seq_pkg.sv
// Shared types and field widths for the serial RTC access sequencer.
package rtc_seq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // Transaction-level states of the top sequencer.
    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_SHIFT,
        S_MODE,
        S_RDATA,
        S_FIN
    } seq_state_t;

    // States of the link bring-up engine.
    typedef enum logic [1:0] {
        I_POLL,
        I_PAUSE,
        I_END
    } init_state_t;
endpackage

// File: rtl/rtc_bit_phy.sv
// Serial clock generator for the RTC link.
// While run is high it makes back-to-back pulses: LINK_DLY cycles low, then
// LINK_DLY cycles high. bit_done marks the last high cycle of each pulse.
// Assumes LINK_DLY >= 1 and that the caller holds data stable over a pulse.
module rtc_bit_phy #(
    parameter int LINK_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic bit_done
);
    localparam int DW = $clog2(LINK_DLY + 1);
    localparam logic [DW-1:0] DLAST = DW'(LINK_DLY - 1);

    logic [DW-1:0] cnt;
    logic          hi;

    // Phase counter: toggles the clock level every LINK_DLY cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (cnt == DLAST) begin
            cnt <= '0;
            hi  <= !hi;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

    assign sclk     = hi;
    assign bit_done = run && hi && (cnt == DLAST);
endmodule

// File: rtl/rtc_link_init.sv
// Link bring-up engine: polls the target ready flag in windows of POLL_LIMIT
// cycles. Each empty window kicks the flag and pauses. After RETRY kicks, one
// more empty window fails the attempt. Failed attempts are retried after a
// pause, and every (RETRY+1)-th failure requests a static-register reset.
// After RETRY resets, the next failed group reports fail.
// Assumes en stays high until ok or fail has been seen; dropping en clears it.
module rtc_link_init #(
    parameter int          POLL_LIMIT = 40000,
    parameter int          PAUSE_DLY  = 5000,
    parameter int          RETRY      = 3,
    parameter logic [15:0] SRST_VALUE = 16'h180A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tgt_ready,
    output logic        ok,
    output logic        fail,
    output logic        rdy_kick,
    output logic        srst_req,
    output logic [15:0] srst_val
);
    import rtc_seq_pkg::*;

    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int QW = $clog2(PAUSE_DLY + 1);
    localparam int RW = $clog2(RETRY + 1);
    localparam logic [PW-1:0] POLL_LAST  = PW'(POLL_LIMIT - 1);
    localparam logic [QW-1:0] PAUSE_LAST = QW'(PAUSE_DLY - 1);
    localparam logic [RW-1:0] R_LAST     = RW'(RETRY);

    init_state_t   st;
    logic [PW-1:0] poll_cnt;
    logic [QW-1:0] pause_cnt;
    logic [RW-1:0] win_cnt;
    logic [RW-1:0] fail_cnt;
    logic [RW-1:0] rst_cnt;

    // Bring-up state machine with nested window / attempt / reset counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st        <= I_POLL;
            poll_cnt  <= '0;
            pause_cnt <= '0;
            win_cnt   <= '0;
            fail_cnt  <= '0;
            rst_cnt   <= '0;
            ok        <= 1'b0;
            fail      <= 1'b0;
            rdy_kick  <= 1'b0;
            srst_req  <= 1'b0;
        end else begin
            ok       <= 1'b0;
            fail     <= 1'b0;
            rdy_kick <= 1'b0;
            srst_req <= 1'b0;
            case (st)
                I_POLL: begin
                    if (tgt_ready) begin
                        ok <= 1'b1;
                        st <= I_END;
                    end else if (poll_cnt == POLL_LAST) begin
                        poll_cnt  <= '0;
                        pause_cnt <= '0;
                        st        <= I_PAUSE;
                        if (win_cnt == R_LAST) begin
                            win_cnt <= '0;
                            if (fail_cnt == R_LAST) begin
                                fail_cnt <= '0;
                                if (rst_cnt == R_LAST) begin
                                    fail <= 1'b1;
                                    st   <= I_END;
                                end else begin
                                    rst_cnt  <= rst_cnt + RW'(1);
                                    srst_req <= 1'b1;
                                end
                            end else begin
                                fail_cnt <= fail_cnt + RW'(1);
                            end
                        end else begin
                            win_cnt  <= win_cnt + RW'(1);
                            rdy_kick <= 1'b1;
                        end
                    end else begin
                        poll_cnt <= poll_cnt + PW'(1);
                    end
                end
                I_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) st <= I_POLL;
                    else pause_cnt <= pause_cnt + QW'(1);
                end
                default: st <= I_END;
            endcase
        end
    end

    assign srst_val = SRST_VALUE;
endmodule

// File: rtl/rtc_serial_seq.sv
// Top of the serial RTC access sequencer. It accepts one read or write
// request, brings the link up through rtc_link_init, and shifts the frame
// with rtc_bit_phy: write = data then address, read = address only. A mode
// pulse with the enable low follows the frame, and a read then clocks in
// 32 bits. Requests that arrive while busy are refused with busy_rej.
// Assumes link_sdo is valid by the end of each high clock phase.
module rtc_serial_seq #(
    parameter int          LINK_DLY   = 250,
    parameter int          PAUSE_DLY  = 5000,
    parameter int          POLL_LIMIT = 40000,
    parameter int          RETRY      = 3,
    parameter logic [15:0] SRST_VALUE = 16'h180A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_wr,
    input  logic [2:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    output logic        done,
    output logic        err,
    output logic        busy_rej,
    output logic        link_sen,
    output logic        link_sclk,
    output logic        link_sdi,
    input  logic        link_sdo,
    input  logic        tgt_ready,
    output logic        rdy_kick,
    output logic        srst_req,
    output logic [15:0] srst_val
);
    import rtc_seq_pkg::*;

    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CW      = $clog2(FRAME_W + 1);

    seq_state_t         st;
    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      bits_left;
    logic               is_wr;
    logic [DATA_W-1:0]  rd_sh;
    logic               err_q;
    logic               sen_q;
    logic               busy_w;
    logic               phy_run;
    logic               bit_done;
    logic               init_ok;
    logic               init_fail;

    assign busy_w  = (st != S_IDLE);
    assign phy_run = (st == S_SHIFT) || (st == S_MODE) || (st == S_RDATA);

    rtc_bit_phy #(.LINK_DLY(LINK_DLY)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (phy_run),
        .sclk     (link_sclk),
        .bit_done (bit_done)
    );

    rtc_link_init #(
        .POLL_LIMIT (POLL_LIMIT),
        .PAUSE_DLY  (PAUSE_DLY),
        .RETRY      (RETRY),
        .SRST_VALUE (SRST_VALUE)
    ) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st == S_INIT),
        .tgt_ready (tgt_ready),
        .ok        (init_ok),
        .fail      (init_fail),
        .rdy_kick  (rdy_kick),
        .srst_req  (srst_req),
        .srst_val  (srst_val)
    );

    // Transaction sequencer: request capture, frame shifting, read-back, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            sh        <= '0;
            bits_left <= '0;
            is_wr     <= 1'b0;
            rd_sh     <= '0;
            rd_data   <= '0;
            err_q     <= 1'b0;
            sen_q     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req) begin
                    is_wr     <= req_wr;
                    sh        <= req_wr ? {req_wdata, req_addr} : {req_addr, {DATA_W{1'b0}}};
                    bits_left <= req_wr ? CW'(FRAME_W) : CW'(ADDR_W);
                    err_q     <= 1'b0;
                    st        <= S_INIT;
                end
                S_INIT: begin
                    if (init_ok) begin
                        sen_q <= 1'b1;
                        st    <= S_SHIFT;
                    end else if (init_fail) begin
                        err_q <= 1'b1;
                        st    <= S_FIN;
                    end
                end
                S_SHIFT: if (bit_done) begin
                    sh <= sh << 1;
                    if (bits_left == CW'(1)) begin
                        sen_q <= 1'b0;
                        st    <= S_MODE;
                    end else begin
                        bits_left <= bits_left - CW'(1);
                    end
                end
                S_MODE: if (bit_done) begin
                    bits_left <= CW'(DATA_W);
                    st        <= is_wr ? S_FIN : S_RDATA;
                end
                S_RDATA: if (bit_done) begin
                    rd_sh <= {rd_sh[DATA_W-2:0], link_sdo};
                    if (bits_left == CW'(1)) begin
                        rd_data <= {rd_sh[DATA_W-2:0], link_sdo};
                        st      <= S_FIN;
                    end else begin
                        bits_left <= bits_left - CW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Busy refusal flag: one cycle after a request that found the block busy.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_rej <= 1'b0;
        else        busy_rej <= req && busy_w;
    end

    assign link_sen = sen_q;
    assign link_sdi = (st == S_SHIFT) ? sh[FRAME_W-1] :
                      (st == S_MODE)  ? is_wr : 1'b0;
    assign done     = (st == S_FIN);
    assign err      = (st == S_FIN) && err_q;
endmodule

// File: rtl/rtc_serial_seq_chk.sv
// Property checker for rtc_serial_seq, attached by bind below.
// It watches the host and link ports plus the internal busy signal.
module rtc_serial_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        busy_rej,
    input logic [31:0] rd_data,
    input logic        link_sen,
    input logic        link_sclk,
    input logic        link_sdi,
    input logic        rdy_kick,
    input logic        srst_req
);
    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R4
    sdi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sclk && $past(link_sclk)) |-> $stable(link_sdi));
    // R5
    idle_link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!link_sen && !link_sclk && !link_sdi));
    // R6
    kick_only_sen_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_kick || srst_req) |-> (!link_sen && !link_sclk));
    // R7
    kick_reset_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_kick && srst_req));
    // R9
    busy_rej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_rej |-> ($past(req) && $past(busy)));
    // R10
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));
endmodule

bind rtc_serial_seq rtc_serial_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy_w),
    .done      (done),
    .err       (err),
    .busy_rej  (busy_rej),
    .rd_data   (rd_data),
    .link_sen  (link_sen),
    .link_sclk (link_sclk),
    .link_sdi  (link_sdi),
    .rdy_kick  (rdy_kick),
    .srst_req  (srst_req)
);

// File: tb/rtc_serial_seq_bench.sv
// Bench for rtc_serial_seq: a link target model, frame decoder and checks.
module rtc_serial_seq_bench;
    localparam int LD = 2;
    localparam int PD = 5;
    localparam int PL = 6;
    localparam int RT = 3;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        done, err, busy_rej;
    logic        link_sen, link_sclk, link_sdi;
    logic        link_sdo = 1'b0;
    logic        tgt_ready;
    logic        rdy_kick, srst_req;
    logic [15:0] srst_val;

    int checks = 0;
    int fails = 0;

    // Target model state and decoded link activity.
    int          need_k = 0;
    int          kicks = 0, srsts = 0, wcnt = 0, rcnt = 0;
    int          bad_tim = 0, bad_init = 0, hi_len = 0;
    logic [63:0] wbits = '0;
    logic        mode_bit = 1'b0;
    logic [31:0] rval = '0;
    logic        sclk_prev = 1'b0, sdi_prev = 1'b0, done_prev = 1'b0;
    logic [31:0] last_rd = '0;

    always #5 clk = !clk;

    assign tgt_ready = (kicks >= need_k);

    rtc_serial_seq #(
        .LINK_DLY(LD), .PAUSE_DLY(PD), .POLL_LIMIT(PL), .RETRY(RT), .SRST_VALUE(16'h180A)
    ) u_rtc_serial_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .err(err),
        .busy_rej(busy_rej), .link_sen(link_sen), .link_sclk(link_sclk),
        .link_sdi(link_sdi), .link_sdo(link_sdo), .tgt_ready(tgt_ready),
        .rdy_kick(rdy_kick), .srst_req(srst_req), .srst_val(srst_val)
    );

    // Link monitor and target model, sampled away from the active edge.
    always @(negedge clk) begin
        if (done_prev) begin
            kicks = 0; srsts = 0; wcnt = 0; rcnt = 0; wbits = '0;
            bad_tim = 0; bad_init = 0; hi_len = 0;
        end else begin
            if (link_sclk && !sclk_prev) begin
                if (link_sen) begin
                    wbits = {wbits[62:0], link_sdi};
                    wcnt++;
                end else begin
                    if (rcnt == 0) mode_bit = link_sdi;
                    else if (rcnt <= 32) link_sdo = rval[32-rcnt];
                    rcnt++;
                end
            end
            if (link_sclk && sclk_prev && (link_sdi != sdi_prev)) bad_tim++;
            if (link_sclk) hi_len++;
            else if (hi_len != 0) begin
                if (hi_len != LD) bad_tim++;
                hi_len = 0;
            end
            if (rdy_kick) kicks++;
            if (srst_req) begin
                srsts++;
                if (srst_val != 16'h180A) bad_init++;
            end
            if (link_sen && !tgt_ready) bad_init++;
        end
        sclk_prev = link_sclk;
        sdi_prev  = link_sdi;
        done_prev = done;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_srst(input int k);
        int f;
        f = (k == 0) ? 0 : (k - 1) / RT;
        return f / (RT + 1);
    endfunction

    task automatic do_txn(input bit wr, input logic [2:0] a, input logic [31:0] d,
                          input logic [31:0] rv, input int need, input bit interfere);
        int cyc;
        bit expect_err;
        expect_err = (need > RT * (RT + 1) * (RT + 1));
        rval = rv;
        need_k = need;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            if (interfere && cyc == 3) begin
                req = 1'b1; req_wr = !wr; req_addr = ~a; req_wdata = ~d;
            end
            if (interfere && cyc == 4) begin
                chk(busy_rej == 1'b1, "R9 busy_rej", 64'(busy_rej), 64'd1);
                req = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        chk(cyc < LIMIT, "R8 watchdog done", 64'(cyc), 64'(LIMIT));
        chk(err == expect_err, "R8 err flag", 64'(err), 64'(expect_err));
        chk(bad_tim == 0, "R4 bit timing", 64'(bad_tim), 64'd0);
        chk(bad_init == 0, "R5 bring-up order", 64'(bad_init), 64'd0);
        if (expect_err) begin
            chk(kicks == RT * (RT + 1) * (RT + 1), "R7 kick total", 64'(kicks), 64'(RT * (RT + 1) * (RT + 1)));
            chk(srsts == RT, "R7 reset total", 64'(srsts), 64'(RT));
            chk(wcnt == 0 && rcnt == 0, "R7 no bits", 64'(wcnt + rcnt), 64'd0);
            chk(rd_data == last_rd, "R10 rd_data kept on error", 64'(rd_data), 64'(last_rd));
        end else begin
            chk(kicks == need, "R6 kick count", 64'(kicks), 64'(need));
            chk(srsts == exp_srst(need), "R7 reset count", 64'(srsts), 64'(exp_srst(need)));
            if (wr) begin
                chk(wcnt == 35, "R2 write bit count", 64'(wcnt), 64'd35);
                chk(wbits[34:0] == {d, a}, "R2 write frame", 64'(wbits[34:0]), 64'({d, a}));
                chk(mode_bit == 1'b1 && rcnt == 1, "R2 write mode", 64'({mode_bit, 8'(rcnt)}), 64'h101);
                chk(rd_data == last_rd, "R10 rd_data kept on write", 64'(rd_data), 64'(last_rd));
            end else begin
                chk(wcnt == 3, "R3 read addr count", 64'(wcnt), 64'd3);
                chk(wbits[2:0] == a, "R3 read addr", 64'(wbits[2:0]), 64'(a));
                chk(mode_bit == 1'b0 && rcnt == 33, "R3 read mode", 64'({mode_bit, 8'(rcnt)}), 64'd33);
                chk(rd_data == rv, "R3 read data", 64'(rd_data), 64'(rv));
                last_rd = rv;
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({link_sen, link_sclk, link_sdi, done, err, busy_rej, rdy_kick, srst_req} == 8'h00,
            "R1 reset outputs", 64'({link_sen, link_sclk, link_sdi, done, err, busy_rej, rdy_kick, srst_req}), 64'd0);
        chk(rd_data == 32'd0, "R1 rd_data reset", 64'(rd_data), 64'd0);

        // Directed corners
        do_txn(1'b1, 3'b101, 32'hA5C3_0F96, 32'h0, 0, 1'b0);
        do_txn(1'b0, 3'b010, 32'h0, 32'h8000_0001, 0, 1'b0);
        do_txn(1'b1, 3'b111, 32'hFFFF_FFFF, 32'h0, 2, 1'b1);
        do_txn(1'b0, 3'b000, 32'h0, 32'h1234_5678, 5, 1'b1);
        do_txn(1'b0, 3'b110, 32'h0, 32'hDEAD_BEEF, 13, 1'b0);
        do_txn(1'b0, 3'b011, 32'h0, 32'h0BAD_F00D, 1000, 1'b0);
        do_txn(1'b1, 3'b001, 32'h0000_0000, 32'h0, 0, 1'b0);

        // Seeded random mix
        r = $urandom(32'h5EED_0042);
        for (int i = 0; i < 16; i++) begin
            do_txn(1'($urandom), 3'($urandom), $urandom, $urandom,
                   int'($urandom % 5), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule